// File: doc/BRIEF.md
# Key-Protected Configuration and Sequencer Memory

This block is a small byte-wide register bank guarding the settings of a power sequencer. Most of its registers cannot be written until software has unlocked them. It does this by writing two chosen bytes, one after the other, into a key register. One byte pair grants a configuration privilege. A second pair grants a test privilege. A third pair grants both at once. Any other write to the key register removes both privileges.

The configuration privilege opens several targets for writing:
- seven sequence start-address registers;
- a boot configuration register;
- an indirect address/data port into a 256-byte sequencer memory, organised as 64 words of 4 byte slots.

Each data write through the port advances the indirect address. Only certain address windows of the memory accept the byte. The test privilege widens the set of writable bits in four dedicated regulator registers. Four device-group registers are always writable, but only in their upper nibble.

Access is through a simple addressed byte bus. A write takes effect at the clock edge where `wr_en` is high. A read returns data on `rdata` one cycle after `rd_en`, and `rdata` holds that value until the next read. Both privilege flags are also driven out as outputs.

Top module: `keyed_cfg_block`

## Requirements
- R1: After synchronous reset, the stored values are as follows. The key register (0x44), the indirect address (0x59) and the start registers (0x52..0x58) read 0x00. The boot register (0x3B) reads 0x38. Every dedicated register (0x7D, 0x85, 0x91, 0x99) reads 0x35. Every device-group register (0x7A, 0x82, 0x8E, 0x96) reads 0x0B. Both `cfg_priv` and `test_priv` are 0.
- R2: Each write to 0x44 sets the privileges from the stored key and the new byte. Stored 0xC0 with new 0x0C gives configuration only. Stored 0x0E with new 0xE0 gives test only. Stored 0xCE with new 0xEC gives both. The flags change at the edge that captures the write.
- R3: Every other write to 0x44 clears both privileges. Every write to 0x44 stores the new byte, and that byte reads back from 0x44.
- R4: Writes to 0x52..0x58 take effect only while the configuration privilege is set. They store the written value AND 0x3F.
- R5: Writes to the indirect address register 0x59 take effect only while the configuration privilege is set. They store all 8 bits.
- R6: A write to 0x5A while the configuration privilege is set always increments 0x59, wrapping from 0xFF to 0x00. It stores the byte in memory at the current address if R7 allows. Word index is address[7:2] and byte slot is address[1:0].
- R7: The memory accepts a byte in two cases: the address lies in 0x2B..0x3E inclusive, or the address is at most 0x0E with byte slot 3. All other memory bytes keep their power-up value of 0x00.
- R8: A write to 0x5A without the configuration privilege stores nothing and leaves 0x59 unchanged.
- R9: Writes to 0x3B take effect only while the configuration privilege is set. Bits in mask 0x70 keep their old value. Bits in mask 0x8F take the written value.
- R10: Each dedicated register has a test mask and a normal mask: 0x7D uses 0x77/0x07, 0x85 and 0x99 use 0x73/0x03, and 0x91 uses 0x7F/0x0F. With the test privilege set, a write stores value AND test mask. Without it, bits 0x70 are kept and only the normal-mask bits are written.
- R11: A write to a device-group register keeps its low nibble and takes its high nibble from the written value, whatever the privileges.
- R12: A read returns data on `rdata` one cycle after `rd_en` and holds it until the next read. A read of 0x5A returns the memory byte at the current indirect address and does not change 0x59. A read of any unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cfg_priv | output | 1 | Configuration privilege flag |
| test_priv | output | 1 | Test privilege flag |

## Verification
Every write takes effect at the rising edge where `wr_en` is sampled high. This holds for the privilege flags, the indirect address and the memory byte. A read issued on the very next cycle therefore already sees the new state. Read data appears on `rdata` after the edge that samples `rd_en`. The bench drives each access on a falling edge and removes it on the next falling edge. It then samples `rdata` and the flag outputs at that falling edge, exactly one register stage after the access. The bench sweeps every possible second key byte after the configuration prefix, and it writes and reads back all 256 memory addresses.

// File: rtl/keycfg_pkg.sv
package keycfg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam addr_t A_KEY      = 8'h44;
  localparam addr_t A_BOOT     = 8'h3B;
  localparam addr_t A_START_LO = 8'h52;
  localparam addr_t A_START_HI = 8'h58;
  localparam addr_t A_MADDR    = 8'h59;
  localparam addr_t A_MDATA    = 8'h5A;
  localparam int    N_START    = int'(A_START_HI) - int'(A_START_LO) + 1;

  localparam byte_t KEY_CFG_1  = 8'hC0;
  localparam byte_t KEY_CFG_2  = 8'h0C;
  localparam byte_t KEY_TST_1  = 8'h0E;
  localparam byte_t KEY_TST_2  = 8'hE0;
  localparam byte_t KEY_BOTH_1 = 8'hCE;
  localparam byte_t KEY_BOTH_2 = 8'hEC;

  localparam byte_t START_MASK = 8'h3F;
  localparam byte_t BOOT_KEEP  = 8'h70;
  localparam byte_t BOOT_NEW   = 8'h8F;
  localparam byte_t DED_KEEP   = 8'h70;
  localparam byte_t GRP_KEEP   = 8'h0F;

  localparam int N_DED = 4;
  localparam int N_GRP = 4;

  typedef struct packed {
    logic cfg;
    logic tst;
  } priv_t;

  function automatic addr_t ded_addr(input int i);
    case (i)
      0: return 8'h7D;
      1: return 8'h85;
      2: return 8'h91;
      default: return 8'h99;
    endcase
  endfunction

  function automatic byte_t ded_tmask(input int i);
    case (i)
      0: return 8'h77;
      2: return 8'h7F;
      default: return 8'h73;
    endcase
  endfunction

  function automatic byte_t ded_nmask(input int i);
    case (i)
      0: return 8'h07;
      2: return 8'h0F;
      default: return 8'h03;
    endcase
  endfunction

  function automatic addr_t grp_addr(input int i);
    case (i)
      0: return 8'h7A;
      1: return 8'h82;
      2: return 8'h8E;
      default: return 8'h96;
    endcase
  endfunction
endpackage

// File: rtl/keycfg_unlock.sv
module keycfg_unlock
  import keycfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_key,
  input  byte_t wdata,
  output byte_t key_q,
  output priv_t priv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      priv_q <= '0;
    end else if (wr_key) begin
      key_q      <= wdata;
      priv_q.cfg <= (key_q == KEY_CFG_1  && wdata == KEY_CFG_2) ||
                    (key_q == KEY_BOTH_1 && wdata == KEY_BOTH_2);
      priv_q.tst <= (key_q == KEY_TST_1  && wdata == KEY_TST_2) ||
                    (key_q == KEY_BOTH_1 && wdata == KEY_BOTH_2);
    end
  end
endmodule

// File: rtl/keycfg_seqmem.sv
module keycfg_seqmem
  import keycfg_pkg::*;
#(
  parameter int    WORDS    = 64,
  parameter int    SLOTS    = 4,
  parameter addr_t WIN_LO   = 8'h2B,
  parameter addr_t WIN_HI   = 8'h3E,
  parameter addr_t LOW_TOP  = 8'h0E,
  parameter int    LOW_SLOT = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  cfg,
  input  logic  wr_addr,
  input  logic  wr_data,
  input  logic  rd_mem,
  input  byte_t wdata,
  output addr_t addr_q,
  output byte_t rd_q
);
  localparam int DEPTH  = WORDS * SLOTS;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SLOT_W = $clog2(SLOTS);

  byte_t ram [DEPTH];
  logic [IDX_W-1:0] idx;
  logic in_win;
  logic we;

  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = '0;
  end

  assign idx    = addr_q[IDX_W-1:0];
  assign in_win = (addr_q >= WIN_LO && addr_q <= WIN_HI) ||
                  (addr_q <= LOW_TOP && addr_q[SLOT_W-1:0] == SLOT_W'(LOW_SLOT));
  assign we     = wr_data && cfg && in_win;

  always_ff @(posedge clk) begin
    if (we) ram[idx] <= wdata;
    if (rd_mem) rd_q <= ram[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (cfg && wr_data) addr_q <= addr_q + 1'b1;
    else if (cfg && wr_addr) addr_q <= wdata;
  end
endmodule

// File: rtl/keycfg_regbank.sv
module keycfg_regbank
  import keycfg_pkg::*;
#(
  parameter byte_t BOOT_RST = 8'h38,
  parameter byte_t DED_RST  = 8'h35,
  parameter byte_t GRP_RST  = 8'h0B
) (
  input  logic  clk,
  input  logic  rst,
  input  priv_t priv,
  input  logic  wr_en,
  input  addr_t addr,
  input  byte_t wdata,
  output logic  rd_hit,
  output byte_t rd_val
);
  byte_t start_q [N_START];
  byte_t ded_q   [N_DED];
  byte_t grp_q   [N_GRP];
  byte_t boot_q;

  for (genvar s = 0; s < N_START; s++) begin : g_start
    always_ff @(posedge clk) begin
      if (rst) start_q[s] <= '0;
      else if (wr_en && priv.cfg && addr == A_START_LO + ADDR_W'(s))
        start_q[s] <= wdata & START_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) boot_q <= BOOT_RST;
    else if (wr_en && priv.cfg && addr == A_BOOT)
      boot_q <= (boot_q & BOOT_KEEP) | (wdata & BOOT_NEW);
  end

  for (genvar d = 0; d < N_DED; d++) begin : g_ded
    always_ff @(posedge clk) begin
      if (rst) ded_q[d] <= DED_RST;
      else if (wr_en && addr == ded_addr(d)) begin
        if (priv.tst) ded_q[d] <= wdata & ded_tmask(d);
        else          ded_q[d] <= (ded_q[d] & DED_KEEP) | (wdata & ded_nmask(d));
      end
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) grp_q[g] <= GRP_RST;
      else if (wr_en && addr == grp_addr(g))
        grp_q[g] <= (grp_q[g] & GRP_KEEP) | (wdata & ~GRP_KEEP);
    end
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_val = '0;
    if (addr == A_BOOT) begin
      rd_hit = 1'b1;
      rd_val = boot_q;
    end
    for (int s = 0; s < N_START; s++) begin
      if (addr == A_START_LO + ADDR_W'(s)) begin
        rd_hit = 1'b1;
        rd_val = start_q[s];
      end
    end
    for (int d = 0; d < N_DED; d++) begin
      if (addr == ded_addr(d)) begin
        rd_hit = 1'b1;
        rd_val = ded_q[d];
      end
    end
    for (int g = 0; g < N_GRP; g++) begin
      if (addr == grp_addr(g)) begin
        rd_hit = 1'b1;
        rd_val = grp_q[g];
      end
    end
  end
endmodule

// File: rtl/keyed_cfg_block.sv
module keyed_cfg_block
  import keycfg_pkg::*;
#(
  parameter int    SEQ_WORDS = 64,
  parameter int    SEQ_SLOTS = 4,
  parameter byte_t BOOT_RST  = 8'h38,
  parameter byte_t DED_RST   = 8'h35,
  parameter byte_t GRP_RST   = 8'h0B
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       cfg_priv,
  output logic       test_priv
);
  byte_t key_q;
  priv_t priv_q;
  addr_t mem_addr_q;
  byte_t mem_rd_q;
  logic  bank_hit;
  byte_t bank_val;
  byte_t rd_comb;
  byte_t rd_reg_q;
  logic  sel_mem_q;

  keycfg_unlock u_unlock (
    .clk    (clk),
    .rst    (rst),
    .wr_key (wr_en && addr == A_KEY),
    .wdata  (wdata),
    .key_q  (key_q),
    .priv_q (priv_q)
  );

  keycfg_seqmem #(
    .WORDS (SEQ_WORDS),
    .SLOTS (SEQ_SLOTS)
  ) u_seqmem (
    .clk     (clk),
    .rst     (rst),
    .cfg     (priv_q.cfg),
    .wr_addr (wr_en && addr == A_MADDR),
    .wr_data (wr_en && addr == A_MDATA),
    .rd_mem  (rd_en && addr == A_MDATA),
    .wdata   (wdata),
    .addr_q  (mem_addr_q),
    .rd_q    (mem_rd_q)
  );

  keycfg_regbank #(
    .BOOT_RST (BOOT_RST),
    .DED_RST  (DED_RST),
    .GRP_RST  (GRP_RST)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .priv   (priv_q),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rd_hit (bank_hit),
    .rd_val (bank_val)
  );

  always_comb begin
    if (addr == A_KEY)       rd_comb = key_q;
    else if (addr == A_MADDR) rd_comb = mem_addr_q;
    else if (bank_hit)       rd_comb = bank_val;
    else                     rd_comb = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg_q  <= '0;
      sel_mem_q <= 1'b0;
    end else if (rd_en) begin
      rd_reg_q  <= rd_comb;
      sel_mem_q <= (addr == A_MDATA);
    end
  end

  assign rdata     = sel_mem_q ? mem_rd_q : rd_reg_q;
  assign cfg_priv  = priv_q.cfg;
  assign test_priv = priv_q.tst;
endmodule

// File: rtl/keyed_cfg_block_chk.sv
module keyed_cfg_block_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       cfg_priv,
  input logic       test_priv,
  input logic [7:0] key_q,
  input logic [7:0] mem_addr_q
);
  p_unlock_cfg_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h44 && key_q == 8'hC0 && wdata == 8'h0C) |=> (cfg_priv && !test_priv));

  p_flag_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 8'h44) |=> ($stable(cfg_priv) && $stable(test_priv)));

  p_key_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h44 && wdata != 8'h0C && wdata != 8'hE0 && wdata != 8'hEC)
      |=> (!cfg_priv && !test_priv));

  p_addr_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h5A && cfg_priv) |=> (mem_addr_q == $past(mem_addr_q) + 8'd1));

  p_no_inc_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h5A && !cfg_priv) |=> $stable(mem_addr_q));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !$past(rst)) |=> $stable(rdata));
endmodule

bind keyed_cfg_block keyed_cfg_block_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .cfg_priv   (cfg_priv),
  .test_priv  (test_priv),
  .key_q      (key_q),
  .mem_addr_q (mem_addr_q)
);

// File: tb/keyed_cfg_block_test.sv
`timescale 1ns/1ps
module keyed_cfg_block_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cfg_priv;
  logic       test_priv;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_cfg_block uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cfg_priv(cfg_priv), .test_priv(test_priv)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic priv_chk(input string tag, input bit c, input bit t);
    chk(tag, {6'd0, cfg_priv, test_priv}, {6'd0, c, t});
  endtask

  function automatic bit in_win(input int a);
    return (a >= 'h2B && a <= 'h3E) || (a <= 'h0E && (a % 4) == 3);
  endfunction

  function automatic logic [7:0] mval(input int a);
    return 8'((a * 7 + 3) % 256);
  endfunction

  logic [7:0] ded_a [4] = '{8'h7D, 8'h85, 8'h91, 8'h99};
  logic [7:0] ded_t [4] = '{8'h77, 8'h73, 8'h7F, 8'h73};
  logic [7:0] ded_n [4] = '{8'h07, 8'h03, 8'h0F, 8'h03};
  logic [7:0] grp_a [4] = '{8'h7A, 8'h82, 8'h8E, 8'h96};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    priv_chk("R1 flags", 1'b0, 1'b0);
    rd_chk("R1 key", 8'h44, 8'h00);
    rd_chk("R1 maddr", 8'h59, 8'h00);
    rd_chk("R1 boot", 8'h3B, 8'h38);
    for (int i = 0; i < 7; i++) rd_chk("R1 start", 8'(8'h52 + i), 8'h00);
    for (int i = 0; i < 4; i++) rd_chk("R1 ded", ded_a[i], 8'h35);
    for (int i = 0; i < 4; i++) rd_chk("R1 grp", grp_a[i], 8'h0B);

    // Unprivileged writes are dropped
    wr(8'h52, 8'hFF); rd_chk("R4 locked", 8'h52, 8'h00);
    wr(8'h59, 8'h10); rd_chk("R5 locked", 8'h59, 8'h00);
    wr(8'h3B, 8'hFF); rd_chk("R9 locked", 8'h3B, 8'h38);
    wr(8'h5A, 8'h77); rd_chk("R8 no increment", 8'h59, 8'h00);
    rd_chk("R8 no store", 8'h5A, 8'h00);

    // R2 / R3: sweep every second byte after the configuration prefix
    for (int s = 0; s < 256; s++) begin
      wr(8'h44, 8'hC0);
      wr(8'h44, 8'(s));
      priv_chk("R2 cfg sweep", s == 'h0C, 1'b0);
    end
    rd_chk("R3 key readback", 8'h44, 8'hFF);
    wr(8'h44, 8'h0E); wr(8'h44, 8'hE0); priv_chk("R2 test only", 1'b0, 1'b1);
    wr(8'h44, 8'hCE); wr(8'h44, 8'hEC); priv_chk("R2 both", 1'b1, 1'b1);
    wr(8'h44, 8'h0C); priv_chk("R3 clear after both", 1'b0, 1'b0);
    wr(8'h44, 8'hCE); wr(8'h44, 8'h0C); priv_chk("R3 wrong pair", 1'b0, 1'b0);
    wr(8'h44, 8'h0E); wr(8'h44, 8'hEC); priv_chk("R3 wrong pair b", 1'b0, 1'b0);

    // R10 normal mode
    for (int i = 0; i < 4; i++) begin
      wr(ded_a[i], 8'hFF); rd_chk("R10 normal ff", ded_a[i], 8'h30 | ded_n[i]);
      wr(ded_a[i], 8'h00); rd_chk("R10 normal 00", ded_a[i], 8'h30);
    end
    // R11 device group, unprivileged
    for (int i = 0; i < 4; i++) begin
      wr(grp_a[i], 8'hA4); rd_chk("R11 grp", grp_a[i], 8'hAB);
    end

    // Configuration privilege
    wr(8'h44, 8'hC0); wr(8'h44, 8'h0C);
    for (int i = 0; i < 7; i++) begin
      wr(8'(8'h52 + i), 8'(8'hA5 ^ (i * 8'h11)));
      rd_chk("R4 start", 8'(8'h52 + i), 8'(8'hA5 ^ (i * 8'h11)) & 8'h3F);
    end
    wr(8'h3B, 8'h00); rd_chk("R9 boot 00", 8'h3B, 8'h30);
    wr(8'h3B, 8'hFF); rd_chk("R9 boot ff", 8'h3B, 8'hBF);
    wr(8'h59, 8'h00); rd_chk("R5 maddr", 8'h59, 8'h00);
    for (int a = 0; a < 256; a++) begin
      wr(8'h5A, mval(a));
      if (a == 4) rd_chk("R6 increment", 8'h59, 8'h05);
    end
    rd_chk("R6 wrap", 8'h59, 8'h00);
    for (int a = 0; a < 256; a++) begin
      wr(8'h59, 8'(a));
      rd_chk("R7 memory", 8'h5A, in_win(a) ? mval(a) : 8'h00);
    end
    rd_chk("R12 read keeps addr", 8'h59, 8'hFF);

    // R10 test mode
    wr(8'h44, 8'h0E); wr(8'h44, 8'hE0);
    for (int i = 0; i < 4; i++) begin
      wr(ded_a[i], 8'hFF); rd_chk("R10 test ff", ded_a[i], ded_t[i]);
    end
    wr(8'h44, 8'h00);
    wr(ded_a[0], 8'h00); rd_chk("R10 keep after lock", ded_a[0], 8'h70);

    // R8 after losing the privilege
    wr(8'h59, 8'h30); rd_chk("R5 locked again", 8'h59, 8'hFF);
    wr(8'h5A, 8'h11); rd_chk("R8 locked addr", 8'h59, 8'hFF);
    rd_chk("R12 unmapped 00", 8'h00, 8'h00);
    rd_chk("R12 unmapped fe", 8'hFE, 8'h00);
    repeat (2) @(negedge clk);
    chk("R12 hold", rdata, 8'h00);

    // R1 reset again after activity
    wr(8'h44, 8'hCE); wr(8'h44, 8'hEC);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    priv_chk("R1 reset flags", 1'b0, 1'b0);
    rd_chk("R1 reset key", 8'h44, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule